// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the software-facing command port of one eight-line interrupt controller. The port is byte wide and has two addresses plus a select for a separate edge/level register. Writes to the even address carry either the start of an initialization sequence or an operation command. Writes to the odd address carry either the words of the initialization sequence or a new interrupt mask. Reads return the request, in-service or mask register, a poll result, or the edge/level register.

The block does not hold the request and in-service bits and does not search priorities. Those belong to a neighbouring priority resolver. The resolver feeds this block its request bits, its in-service bits and the line it currently wants to raise. In return the block drives clear pulses for in-service and request bits, an edge-request drop pulse at initialization, and the configuration state: mask, rotation offset, vector base, special mask, nested mode, auto-EOI and rotate-on-auto-EOI.

The initialization sequencer has four named states:
- `ST_READY`: normal operation; odd writes load the mask.
- `ST_BASE`: waiting for the vector base.
- `ST_CASC`: waiting for the cascade word.
- `ST_MODE`: waiting for the optional mode word.

Its transitions are:
- INIT_START: any state to `ST_BASE`, on an even write with bit 4 set.
- BASE_TAKEN: `ST_BASE` to `ST_CASC`.
- CASC_TO_MODE: `ST_CASC` to `ST_MODE`, when a mode word was announced.
- CASC_DONE: `ST_CASC` to `ST_READY`, when no mode word was announced.
- MODE_DONE: `ST_MODE` to `ST_READY`.

Top module: `irq_cmd_decoder`

## Requirements
- R1: After reset the mask, edge/level register and rotation offset are 0, the sequencer is in `ST_READY` (`init_busy_o` low), and an even read returns the request bits.
- R2: An even write with bit 4 set starts initialization. It pulses `init_pulse_o` during the write. After the write it clears the mask, rotation offset, special mask and read select. Nested and auto-EOI modes are cleared only when bit 0 of the write is 0; bit 0 = 1 announces a mode word and leaves them unchanged.
- R3: In initialization, odd writes are taken in a fixed order. The first is the vector base, taken from bits 7:3. The second is the cascade word, which is ignored. The third, present only if announced, is the mode word: bit 4 sets nested mode and bit 1 sets auto-EOI. `init_busy_o` stays high until the sequence ends, and the mask is not touched during it.
- R4: In `ST_READY` an odd write loads the mask with the written byte.
- R5: An even write with bit 4 clear and bit 3 set is a read-control command. Bit 2 = 1 arms a poll. Bit 1 = 1 loads the read select from bit 0 (1 selects in-service, 0 selects request). Bit 6 = 1 loads the special mask from bit 5; with bit 6 = 0 the special mask is unchanged.
- R6: An even write with bits 4 and 3 clear and bits 7:5 equal to 0 or 4 clears or sets rotate-on-auto-EOI.
- R7: Command code 1 (bits 7:5) clears the best-ranked in-service bit, or nothing if none is set. Ranking starts at the line equal to the rotation offset and goes upward modulo 8. Code 5 does the same and also sets the offset to that line plus 1, modulo 8. At most one clear bit is ever raised by a write.
- R8: Code 3 clears the in-service bit of line bits 2:0. Code 7 does the same and sets the offset to that line plus 1, modulo 8. Code 6 sets the offset to bits 2:0 plus 1, modulo 8. Code 2 changes nothing.
- R9: A read while a poll is armed returns 0x80 ORed with the resolver's wanted line. During that read it raises the in-service and request clear bit of that line. With no wanted line it returns 0x07 and clears nothing. The poll disarms after one read.
- R10: Without an armed poll, an even read returns in-service or request bits according to the read select, an odd read returns the mask, and a read with `elcr_sel_i` high returns the edge/level register.
- R11: A write with `elcr_sel_i` high stores the byte ANDed with a fixed mask: 0xF8 when `IS_SLAVE` is 0, 0xDE when it is 1.
- R12: Stored state changes only at the clock edge that ends a write strobe (or a poll read). Clear pulses and read data are combinational while the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr_i | input | 1 | 0 = even (command) address, 1 = odd (data) address |
| elcr_sel_i | input | 1 | Selects the edge/level register instead of the controller |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while `rd_en` is high |
| irr_i | input | 8 | Request bits from the resolver |
| isr_i | input | 8 | In-service bits from the resolver |
| req_valid_i | input | 1 | The resolver has a line to raise |
| req_line_i | input | 3 | The line the resolver wants to raise |
| isr_clr_o | output | 8 | In-service clear bits |
| irr_clr_o | output | 8 | Request clear bits (poll) |
| init_pulse_o | output | 1 | Drop edge requests and level history |
| imr_o | output | 8 | Interrupt mask |
| elcr_o | output | 8 | Edge/level select, 1 = level |
| prio_off_o | output | 3 | Rotation offset (lowest-ranked line is offset-1) |
| vec_base_o | output | 5 | Vector base, bits 7:3 |
| special_mask_o | output | 1 | Special mask mode |
| nested_o | output | 1 | Special nested mode |
| auto_eoi_o | output | 1 | Auto-EOI mode |
| rot_aeoi_o | output | 1 | Rotate on auto-EOI |
| init_busy_o | output | 1 | Initialization sequence in progress |

## Verification
Non-specific EOI is applied with several in-service patterns under several offsets. These include a set bit below the offset, which proves the search wraps, and an empty pattern, which proves nothing is cleared. Each specific and rotating command is checked for both the bit it clears and the offset it leaves behind. Poll reads are tried with and without a wanted line and on both addresses, and the bench follows each with a plain read to show the poll disarmed. Initialization runs both with and without the mode word, from a state where nested and auto-EOI are set, to separate the two clearing rules.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_BASE  = 2'd1,
        ST_CASC  = 2'd2,
        ST_MODE  = 2'd3
    } init_st_t;

    localparam logic [2:0] OP_ROT_CLR = 3'd0;
    localparam logic [2:0] OP_NS_EOI  = 3'd1;
    localparam logic [2:0] OP_NOP     = 3'd2;
    localparam logic [2:0] OP_SP_EOI  = 3'd3;
    localparam logic [2:0] OP_ROT_SET = 3'd4;
    localparam logic [2:0] OP_NS_ROT  = 3'd5;
    localparam logic [2:0] OP_SET_OFF = 3'd6;
    localparam logic [2:0] OP_SP_ROT  = 3'd7;
endpackage

// File: rtl/irq_rank_pick.sv
module irq_rank_pick #(
    parameter int LW = 3
) (
    input  logic [(1<<LW)-1:0] req_i,
    input  logic [LW-1:0]      start_i,
    output logic               found_o,
    output logic [LW-1:0]      line_o
);
    localparam int N = 1 << LW;

    always_comb begin
        found_o = 1'b0;
        line_o  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req_i[start_i + LW'(k)]) begin
                found_o = 1'b1;
                line_o  = start_i + LW'(k);
            end
        end
    end
endmodule

// File: rtl/irq_init_seq.sv
module irq_init_seq
    import irq_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     want_mode_i,
    input  logic     odd_wr_i,
    output init_st_t state_o,
    output logic     ld_base_o,
    output logic     ld_mode_o,
    output logic     ld_mask_o
);
    init_st_t state_q, state_d;
    logic     want_mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_READY;
            want_mode_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_i) want_mode_q <= want_mode_i;
        end
    end

    always_comb begin
        state_d   = state_q;
        ld_base_o = 1'b0;
        ld_mode_o = 1'b0;
        ld_mask_o = 1'b0;
        if (start_i) begin
            state_d = ST_BASE;
        end else if (odd_wr_i) begin
            unique case (state_q)
                ST_READY: ld_mask_o = 1'b1;
                ST_BASE: begin
                    ld_base_o = 1'b1;
                    state_d   = ST_CASC;
                end
                ST_CASC: state_d = want_mode_q ? ST_MODE : ST_READY;
                ST_MODE: begin
                    ld_mode_o = 1'b1;
                    state_d   = ST_READY;
                end
            endcase
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/irq_ocw_decode.sv
module irq_ocw_decode
    import irq_cmd_pkg::*;
#(
    parameter int LW = 3
) (
    input  logic                cmd_wr_i,
    input  logic [7:0]          wdata_i,
    input  logic [(1<<LW)-1:0]  isr_i,
    input  logic [LW-1:0]       off_i,
    output logic [(1<<LW)-1:0]  isr_clr_o,
    output logic                off_ld_o,
    output logic [LW-1:0]       off_val_o,
    output logic                rot_ld_o,
    output logic                poll_set_o,
    output logic                rsel_ld_o,
    output logic                smask_ld_o
);
    logic          best_ok;
    logic [LW-1:0] best_line;
    logic [LW-1:0] spec_line;
    logic [2:0]    op;
    logic          is_ctl;

    irq_rank_pick #(.LW(LW)) u_pick (
        .req_i   (isr_i),
        .start_i (off_i),
        .found_o (best_ok),
        .line_o  (best_line)
    );

    assign spec_line = wdata_i[LW-1:0];
    assign op        = wdata_i[7:5];
    assign is_ctl    = wdata_i[3];

    always_comb begin
        isr_clr_o  = '0;
        off_ld_o   = 1'b0;
        off_val_o  = '0;
        rot_ld_o   = 1'b0;
        poll_set_o = 1'b0;
        rsel_ld_o  = 1'b0;
        smask_ld_o = 1'b0;
        if (cmd_wr_i && is_ctl) begin
            poll_set_o = wdata_i[2];
            rsel_ld_o  = wdata_i[1];
            smask_ld_o = wdata_i[6];
        end else if (cmd_wr_i) begin
            unique case (op)
                OP_ROT_CLR, OP_ROT_SET: rot_ld_o = 1'b1;
                OP_NS_EOI, OP_NS_ROT: begin
                    if (best_ok) begin
                        isr_clr_o[best_line] = 1'b1;
                        off_ld_o  = (op == OP_NS_ROT);
                        off_val_o = best_line + 1'b1;
                    end
                end
                OP_SP_EOI: isr_clr_o[spec_line] = 1'b1;
                OP_SET_OFF: begin
                    off_ld_o  = 1'b1;
                    off_val_o = spec_line + 1'b1;
                end
                OP_SP_ROT: begin
                    isr_clr_o[spec_line] = 1'b1;
                    off_ld_o  = 1'b1;
                    off_val_o = spec_line + 1'b1;
                end
                OP_NOP: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder
    import irq_cmd_pkg::*;
#(
    parameter bit IS_SLAVE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       addr_i,
    input  logic       elcr_sel_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    input  logic [7:0] irr_i,
    input  logic [7:0] isr_i,
    input  logic       req_valid_i,
    input  logic [2:0] req_line_i,
    output logic [7:0] isr_clr_o,
    output logic [7:0] irr_clr_o,
    output logic       init_pulse_o,
    output logic [7:0] imr_o,
    output logic [7:0] elcr_o,
    output logic [2:0] prio_off_o,
    output logic [4:0] vec_base_o,
    output logic       special_mask_o,
    output logic       nested_o,
    output logic       auto_eoi_o,
    output logic       rot_aeoi_o,
    output logic       init_busy_o
);
    localparam int         LW        = 3;
    localparam int         NL        = 1 << LW;
    localparam logic [7:0] ELCR_MASK = IS_SLAVE ? 8'hDE : 8'hF8;

    logic [NL-1:0] imr_q, elcr_q;
    logic [LW-1:0] off_q;
    logic [4:0]    base_q;
    logic          smask_q, rsel_q, poll_q, nested_q, aeoi_q, rot_q;

    logic          ctl_wr, elcr_wr, even_wr, odd_wr, init_start, cmd_wr;
    logic          poll_rd;
    init_st_t      st;
    logic          ld_base, ld_mode, ld_mask;
    logic [NL-1:0] ocw_clr, poll_clr;
    logic          off_ld, rot_ld, poll_set, rsel_ld, smask_ld;
    logic [LW-1:0] off_val;

    assign ctl_wr     = wr_en && !elcr_sel_i;
    assign elcr_wr    = wr_en && elcr_sel_i;
    assign even_wr    = ctl_wr && !addr_i;
    assign odd_wr     = ctl_wr && addr_i;
    assign init_start = even_wr && wdata_i[4];
    assign cmd_wr     = even_wr && !wdata_i[4];
    assign poll_rd    = rd_en && !elcr_sel_i && poll_q;

    irq_init_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (init_start),
        .want_mode_i (wdata_i[0]),
        .odd_wr_i    (odd_wr),
        .state_o     (st),
        .ld_base_o   (ld_base),
        .ld_mode_o   (ld_mode),
        .ld_mask_o   (ld_mask)
    );

    irq_ocw_decode #(.LW(LW)) u_ocw (
        .cmd_wr_i   (cmd_wr),
        .wdata_i    (wdata_i),
        .isr_i      (isr_i),
        .off_i      (off_q),
        .isr_clr_o  (ocw_clr),
        .off_ld_o   (off_ld),
        .off_val_o  (off_val),
        .rot_ld_o   (rot_ld),
        .poll_set_o (poll_set),
        .rsel_ld_o  (rsel_ld),
        .smask_ld_o (smask_ld)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q    <= '0;
            elcr_q   <= '0;
            off_q    <= '0;
            base_q   <= '0;
            smask_q  <= 1'b0;
            rsel_q   <= 1'b0;
            poll_q   <= 1'b0;
            nested_q <= 1'b0;
            aeoi_q   <= 1'b0;
            rot_q    <= 1'b0;
        end else begin
            if (elcr_wr) elcr_q <= wdata_i & ELCR_MASK;
            if (init_start) begin
                imr_q   <= '0;
                off_q   <= '0;
                smask_q <= 1'b0;
                rsel_q  <= 1'b0;
                if (!wdata_i[0]) begin
                    nested_q <= 1'b0;
                    aeoi_q   <= 1'b0;
                end
            end else begin
                if (ld_mask)  imr_q   <= wdata_i;
                if (ld_base)  base_q  <= wdata_i[7:3];
                if (ld_mode) begin
                    nested_q <= wdata_i[4];
                    aeoi_q   <= wdata_i[1];
                end
                if (off_ld)   off_q   <= off_val;
                if (rot_ld)   rot_q   <= wdata_i[7];
                if (rsel_ld)  rsel_q  <= wdata_i[0];
                if (smask_ld) smask_q <= wdata_i[5];
            end
            if (poll_set)     poll_q <= 1'b1;
            else if (poll_rd) poll_q <= 1'b0;
        end
    end

    always_comb begin
        poll_clr = '0;
        if (poll_rd && req_valid_i) poll_clr[req_line_i] = 1'b1;
    end

    always_comb begin
        if (elcr_sel_i)       rdata_o = elcr_q;
        else if (poll_q)      rdata_o = req_valid_i ? {5'b10000, req_line_i} : 8'h07;
        else if (addr_i)      rdata_o = imr_q;
        else if (rsel_q)      rdata_o = isr_i;
        else                  rdata_o = irr_i;
        if (!rd_en) rdata_o = '0;
    end

    assign isr_clr_o      = ocw_clr | poll_clr;
    assign irr_clr_o      = poll_clr;
    assign init_pulse_o   = init_start;
    assign imr_o          = imr_q;
    assign elcr_o         = elcr_q;
    assign prio_off_o     = off_q;
    assign vec_base_o     = base_q;
    assign special_mask_o = smask_q;
    assign nested_o       = nested_q;
    assign auto_eoi_o     = aeoi_q;
    assign rot_aeoi_o     = rot_q;
    assign init_busy_o    = (st != ST_READY);
endmodule

// File: rtl/irq_cmd_checker.sv
module irq_cmd_checker #(
    parameter bit IS_SLAVE = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       addr_i,
    input logic       elcr_sel_i,
    input logic [7:0] wdata_i,
    input logic [7:0] rdata_o,
    input logic [7:0] isr_clr_o,
    input logic [7:0] irr_clr_o,
    input logic       init_pulse_o,
    input logic [7:0] imr_o,
    input logic [7:0] elcr_o,
    input logic [2:0] prio_off_o,
    input logic       init_busy_o
);
    localparam logic [7:0] FIXED_MASK = IS_SLAVE ? 8'hDE : 8'hF8;

    logic init_wr, code7_wr;
    assign init_wr  = wr_en && !elcr_sel_i && !addr_i && wdata_i[4];
    assign code7_wr = wr_en && !elcr_sel_i && !addr_i && !wdata_i[4]
                      && !wdata_i[3] && (wdata_i[7:5] == 3'd7);

    AST_INIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |-> init_pulse_o); // R2
    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> init_busy_o && imr_o == 8'h00 && prio_off_o == 3'd0); // R2
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !elcr_sel_i && addr_i && !init_busy_o) |=> imr_o == $past(wdata_i)); // R4
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |-> $onehot0(isr_clr_o)); // R7
    AST_SPEC_ROT: assert property (@(posedge clk) disable iff (!rst_n)
        code7_wr |=> prio_off_o == 3'($past(wdata_i[2:0]) + 3'd1)); // R8
    AST_POLL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && irr_clr_o != 8'h00) |->
            rdata_o[7] && irr_clr_o == (8'b1 << rdata_o[2:0]) && isr_clr_o == irr_clr_o); // R9
    AST_ELCR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && elcr_sel_i) |=> elcr_o == ($past(wdata_i) & FIXED_MASK)); // R11
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(imr_o) && $stable(elcr_o) && $stable(prio_off_o)); // R12
endmodule

bind irq_cmd_decoder irq_cmd_checker #(.IS_SLAVE(IS_SLAVE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr_i       (addr_i),
    .elcr_sel_i   (elcr_sel_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .isr_clr_o    (isr_clr_o),
    .irr_clr_o    (irr_clr_o),
    .init_pulse_o (init_pulse_o),
    .imr_o        (imr_o),
    .elcr_o       (elcr_o),
    .prio_off_o   (prio_off_o),
    .init_busy_o  (init_busy_o)
);

// File: tb/sim_irq_cmd_decoder.sv
module sim_irq_cmd_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, addr_i = 1'b0, elcr_sel_i = 1'b0;
    logic [7:0] wdata_i = '0, irr_i = '0, isr_i = '0;
    logic req_valid_i = 1'b0;
    logic [2:0] req_line_i = '0;

    logic [7:0] rdata_o, isr_clr_o, irr_clr_o, imr_o, elcr_o;
    logic [2:0] prio_off_o;
    logic [4:0] vec_base_o;
    logic init_pulse_o, special_mask_o, nested_o, auto_eoi_o, rot_aeoi_o, init_busy_o;

    logic [7:0] s_rdata, s_isr_clr, s_irr_clr, s_imr, s_elcr;
    logic [2:0] s_off;
    logic [4:0] s_base;
    logic s_pulse, s_smask, s_nested, s_aeoi, s_rot, s_busy;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_cmd_decoder #(.IS_SLAVE(1'b0)) u0 (
        .clk, .rst_n, .wr_en, .rd_en, .addr_i, .elcr_sel_i, .wdata_i, .rdata_o,
        .irr_i, .isr_i, .req_valid_i, .req_line_i, .isr_clr_o, .irr_clr_o,
        .init_pulse_o, .imr_o, .elcr_o, .prio_off_o, .vec_base_o,
        .special_mask_o, .nested_o, .auto_eoi_o, .rot_aeoi_o, .init_busy_o
    );

    irq_cmd_decoder #(.IS_SLAVE(1'b1)) u1 (
        .clk, .rst_n, .wr_en, .rd_en, .addr_i, .elcr_sel_i, .wdata_i,
        .rdata_o(s_rdata), .irr_i, .isr_i, .req_valid_i, .req_line_i,
        .isr_clr_o(s_isr_clr), .irr_clr_o(s_irr_clr), .init_pulse_o(s_pulse),
        .imr_o(s_imr), .elcr_o(s_elcr), .prio_off_o(s_off), .vec_base_o(s_base),
        .special_mask_o(s_smask), .nested_o(s_nested), .auto_eoi_o(s_aeoi),
        .rot_aeoi_o(s_rot), .init_busy_o(s_busy)
    );

    typedef struct packed {
        logic       rd;
        logic       sel;
        logic       a;
        logic [7:0] d;
        logic [7:0] irr;
        logic [7:0] isr;
        logic       rv;
        logic [2:0] rl;
        logic [7:0] eclr;
        logic [7:0] erd;
        logic [2:0] eoff;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,8'h11,8'h00,8'h00,1'b0,3'd0,8'h00,8'h00,3'd0}, // R2 init, mode word follows
        '{1'b0,1'b0,1'b1,8'h40,8'h00,8'h00,1'b0,3'd0,8'h00,8'h00,3'd0}, // R3 base
        '{1'b0,1'b0,1'b1,8'h00,8'h00,8'h00,1'b0,3'd0,8'h00,8'h00,3'd0}, // R3 cascade
        '{1'b0,1'b0,1'b1,8'h12,8'h00,8'h00,1'b0,3'd0,8'h00,8'h00,3'd0}, // R3 mode word
        '{1'b0,1'b0,1'b1,8'h00,8'h00,8'h00,1'b0,3'd0,8'h00,8'h00,3'd0}, // R4 mask
        '{1'b0,1'b0,1'b0,8'h20,8'h00,8'h28,1'b0,3'd0,8'h08,8'h00,3'd0}, // R7 NS EOI off0
        '{1'b0,1'b0,1'b0,8'h20,8'h00,8'h00,1'b0,3'd0,8'h00,8'h00,3'd0}, // R7 none set
        '{1'b0,1'b0,1'b0,8'hC4,8'h00,8'h00,1'b0,3'd0,8'h00,8'h00,3'd5}, // R8 set offset
        '{1'b0,1'b0,1'b0,8'h20,8'h00,8'h28,1'b0,3'd0,8'h20,8'h00,3'd5}, // R7 off5
        '{1'b0,1'b0,1'b0,8'h20,8'h00,8'h09,1'b0,3'd0,8'h01,8'h00,3'd5}, // R7 wrap
        '{1'b0,1'b0,1'b0,8'hA0,8'h00,8'h48,1'b0,3'd0,8'h40,8'h00,3'd7}, // R7 rotating NS
        '{1'b0,1'b0,1'b0,8'h62,8'h00,8'h00,1'b0,3'd0,8'h04,8'h00,3'd7}, // R8 specific
        '{1'b0,1'b0,1'b0,8'hE3,8'h00,8'h00,1'b0,3'd0,8'h08,8'h00,3'd4}, // R8 specific rotate
        '{1'b0,1'b0,1'b0,8'h40,8'h00,8'hFF,1'b0,3'd0,8'h00,8'h00,3'd4}, // R8 code 2 no-op
        '{1'b0,1'b0,1'b0,8'h0C,8'h00,8'h00,1'b0,3'd0,8'h00,8'h00,3'd4}, // R5 arm poll
        '{1'b1,1'b0,1'b0,8'h00,8'h00,8'h00,1'b1,3'd6,8'h40,8'h86,3'd4}, // R9 poll hit
        '{1'b1,1'b0,1'b0,8'h00,8'h5A,8'h11,1'b0,3'd0,8'h00,8'h5A,3'd4}, // R10 poll gone, IRR
        '{1'b0,1'b0,1'b0,8'h0B,8'h00,8'h00,1'b0,3'd0,8'h00,8'h00,3'd4}, // R5 select ISR
        '{1'b1,1'b0,1'b0,8'h00,8'h5A,8'h11,1'b0,3'd0,8'h00,8'h11,3'd4}, // R10 ISR read
        '{1'b0,1'b0,1'b0,8'h0C,8'h00,8'h00,1'b0,3'd0,8'h00,8'h00,3'd4}, // R5 arm poll
        '{1'b1,1'b0,1'b1,8'h00,8'h00,8'h00,1'b0,3'd0,8'h00,8'h07,3'd4}, // R9 empty poll
        '{1'b0,1'b0,1'b1,8'hA5,8'h00,8'h00,1'b0,3'd0,8'h00,8'h00,3'd4}, // R4 mask
        '{1'b1,1'b0,1'b1,8'h00,8'h00,8'h00,1'b0,3'd0,8'h00,8'hA5,3'd4}, // R10 mask read
        '{1'b0,1'b1,1'b0,8'hFF,8'h00,8'h00,1'b0,3'd0,8'h00,8'h00,3'd4}, // R11 edge/level
        '{1'b1,1'b1,1'b0,8'h00,8'h00,8'h00,1'b0,3'd0,8'h00,8'hF8,3'd4}  // R11 / R10 readback
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic rd, input logic sel, input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = !rd; rd_en = rd; elcr_sel_i = sel; addr_i = a; wdata_i = d;
    endtask

    task automatic release_bus();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; elcr_sel_i = 1'b0; addr_i = 1'b0;
        #1;
    endtask

    task automatic wr(input logic sel, input logic a, input logic [7:0] d);
        drive(1'b0, sel, a, d);
        release_bus();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 mask", imr_o, 8'h00);
        chk("R1 elcr", elcr_o, 8'h00);
        chk("R1 offset", prio_off_o, 3'd0);
        chk("R1 busy", init_busy_o, 1'b0);
        irr_i = 8'h96;
        drive(1'b1, 1'b0, 1'b0, 8'h00); #1;
        chk("R1 read IRR", rdata_o, 8'h96);
        release_bus();

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].rd, VEC[i].sel, VEC[i].a, VEC[i].d);
            irr_i = VEC[i].irr; isr_i = VEC[i].isr;
            req_valid_i = VEC[i].rv; req_line_i = VEC[i].rl;
            #1;
            chk("R7/R8/R9 clear", isr_clr_o, VEC[i].eclr);
            if (VEC[i].rd) chk("R9/R10 rdata", rdata_o, VEC[i].erd);
            release_bus();
            req_valid_i = 1'b0;
            chk("R7/R8 offset", prio_off_o, VEC[i].eoff);
        end
        chk("R3 base", vec_base_o, 5'h08);
        chk("R3 nested", nested_o, 1'b1);
        chk("R3 aeoi", auto_eoi_o, 1'b1);

        // R12: no change before the edge
        drive(1'b0, 1'b0, 1'b1, 8'h3C); #1;
        chk("R12 mask before edge", imr_o, 8'hA5);
        release_bus();
        chk("R12 mask after edge", imr_o, 8'h3C);

        // R9: request clear during poll, then disarmed
        wr(1'b0, 1'b0, 8'h0C);
        drive(1'b1, 1'b0, 1'b0, 8'h00);
        req_valid_i = 1'b1; req_line_i = 3'd1; #1;
        chk("R9 irr clear", irr_clr_o, 8'h02);
        chk("R9 read", rdata_o, 8'h81);
        release_bus();
        isr_i = 8'h77;
        drive(1'b1, 1'b0, 1'b0, 8'h00); #1;
        chk("R9 disarmed read ISR", rdata_o, 8'h77);
        chk("R9 disarmed no clear", irr_clr_o, 8'h00);
        release_bus();
        req_valid_i = 1'b0;

        // R6
        wr(1'b0, 1'b0, 8'h80);
        chk("R6 set", rot_aeoi_o, 1'b1);
        wr(1'b0, 1'b0, 8'h00);
        chk("R6 clear", rot_aeoi_o, 1'b0);

        // R5 special mask
        wr(1'b0, 1'b0, 8'h68);
        chk("R5 smask set", special_mask_o, 1'b1);
        wr(1'b0, 1'b0, 8'h28);
        chk("R5 smask untouched", special_mask_o, 1'b1);
        wr(1'b0, 1'b0, 8'h48);
        chk("R5 smask clear", special_mask_o, 1'b0);

        // R2 init with mode word keeps nested/aeoi
        drive(1'b0, 1'b0, 1'b0, 8'h11); #1;
        chk("R2 pulse", init_pulse_o, 1'b1);
        release_bus();
        chk("R2 busy", init_busy_o, 1'b1);
        chk("R2 mask clr", imr_o, 8'h00);
        chk("R2 offset clr", prio_off_o, 3'd0);
        chk("R2 nested kept", nested_o, 1'b1);
        chk("R2 aeoi kept", auto_eoi_o, 1'b1);
        irr_i = 8'h3E;
        drive(1'b1, 1'b0, 1'b0, 8'h00); #1;
        chk("R2 read select cleared", rdata_o, 8'h3E);
        release_bus();
        wr(1'b0, 1'b1, 8'h40);
        chk("R3 mask untouched", imr_o, 8'h00);
        wr(1'b0, 1'b1, 8'hFF);
        chk("R3 awaiting mode", init_busy_o, 1'b1);
        wr(1'b0, 1'b1, 8'h02);
        chk("R3 mode nested", nested_o, 1'b0);
        chk("R3 mode aeoi", auto_eoi_o, 1'b1);
        chk("R3 done", init_busy_o, 1'b0);
        chk("R3 mask after seq", imr_o, 8'h00);

        // R2 init without mode word clears aeoi; R3 short sequence; R4
        wr(1'b0, 1'b0, 8'h10);
        chk("R2 aeoi cleared", auto_eoi_o, 1'b0);
        wr(1'b0, 1'b1, 8'h68);
        chk("R3 base short", vec_base_o, 5'h0D);
        wr(1'b0, 1'b1, 8'h00);
        chk("R3 short done", init_busy_o, 1'b0);
        wr(1'b0, 1'b1, 8'h33);
        chk("R4 mask load", imr_o, 8'h33);

        // R11 slave mask
        wr(1'b1, 1'b0, 8'hFF);
        chk("R11 slave elcr", s_elcr, 8'hDE);
        chk("R11 master elcr", elcr_o, 8'hF8);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule